// File: doc/BRIEF.md
# Compare-Triggered ADC Start Controller

This block pairs a free-running 16-bit timer with an equality comparator. When the comparator is placed in its trigger mode, each match restarts the timer and, if the converter path is enabled and idle, launches an acquisition-then-conversion sequence. The result is a periodic sampling engine that repeats with no software work beyond collecting results and acknowledging the interrupt.

Software programs the block through a small write-only register port. It sets the compare value, a mode field, a converter enable, and an acquisition-delay selector. It can also start a conversion by hand and clear the sticky completion flag. The analog converter is represented by a fixed-latency stub inside the block. The stub answers every start pulse with a one-cycle done pulse.

A single match event has two effects that are gated independently. The timer restart depends only on the mode field. The converter start depends also on the enable bit and on the converter being idle.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While reset is held, timer_val, trig_evt, go_busy, conv_start and adc_irq are all 0.
- R2: When the mode field (register 1, bits 3:0) is not 4'b1011, the timer increments by one every cycle and wraps. A compare match neither clears it nor pulses trig_evt.
- R3: When the mode field is 4'b1011 and timer_val equals the compare value (register 0, all bits), trig_evt is high for exactly one cycle and timer_val reads 0 in that same cycle. The trigger therefore repeats every compare+1 cycles.
- R4: A trigger pulse seen while the enable bit (register 1, bit 4) is 1 and go_busy is 0 sets go_busy on the next cycle.
- R5: A trigger pulse seen while the enable bit is 0 leaves go_busy at 0, but the timer is still cleared.
- R6: A trigger pulse seen while go_busy is 1 starts no further conversion, but the timer is still cleared. go_busy stays 1 until the converter reports done.
- R7: conv_start rises N cycles after go_busy rises, where N = TAD_DIV × {0,2,4,6,8,12,16,20} for selector values 0..7 (register 1, bits 7:5). Selector 0 means conv_start rises in the same cycle as go_busy.
- R8: conv_start is a one-cycle pulse. conv_done follows CONV_LAT+1 cycles later. In the cycle after conv_done, adc_irq rises and go_busy falls, which is CONV_LAT+2 cycles after conv_start.
- R9: adc_irq is sticky. Writing 0 to bit 0 of register 3 clears it, writing 1 there has no effect, and a done event in the same cycle as a clear wins.
- R10: Writing 1 to bit 0 of register 2 while the enable bit is 1 and go_busy is 0 starts the same sequence without disturbing the timer. With the enable bit at 0, such a write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare, 1 control, 2 go, 3 interrupt flag |
| wr_data | input | TMR_W | Write data |
| timer_val | output | TMR_W | Current timer count |
| trig_evt | output | 1 | One-cycle compare trigger pulse |
| go_busy | output | 1 | Acquisition or conversion in progress |
| conv_start | output | 1 | One-cycle start pulse to the converter stub |
| conv_done | output | 1 | One-cycle done pulse from the converter stub |
| adc_irq | output | 1 | Sticky conversion-complete flag |

## Verification
The hardest situation to reach is a trigger that lands while a conversion is already running. Only in that situation do the two effects of a match come apart: the timer clears while the converter ignores the trigger. The stimulus sets the longest acquisition delay and a short compare period, so that several matches fall inside one busy window. It then turns the enable off before completion, so that no new sequence begins once the window closes. A scoreboard queues the expected acquisition length for each sequence and pairs it with the measured go-to-start distance.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam logic [3:0] MODE_ADC_TRIG = 4'b1011;

  typedef enum logic [1:0] {
    REG_CMP  = 2'd0,
    REG_CTRL = 2'd1,
    REG_GO   = 2'd2,
    REG_IRQ  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACQ  = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_e;

  // Conversion-clock periods of acquisition for each selector value.
  function automatic int unsigned acq_periods(input logic [2:0] sel);
    int unsigned s;
    s = int'(sel);
    if (s <= 4) return 2 * s;
    return 4 * s - 8;
  endfunction

endpackage

// File: rtl/adc_trig_timer.sv
module adc_trig_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_mode,
  input  logic [TMR_W-1:0] cmp_val,
  output logic [TMR_W-1:0] cnt_q,
  output logic             trig_q
);

  logic hit;
  assign hit = trig_mode && (cnt_q == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= hit;
      cnt_q  <= hit ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int TAD_DIV = 2,
  localparam int ACQ_MAX = 20 * TAD_DIV,
  localparam int CNT_W = $clog2(ACQ_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig,
  input  logic       sw_go,
  input  logic       adc_en,
  input  logic [2:0] acq_sel,
  input  logic       irq_wr,
  input  logic       irq_wr_val,
  input  logic       conv_done,
  output logic       go_q,
  output logic       conv_start_q,
  output logic       irq_q
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] acq_cnt_q;
  logic [CNT_W-1:0] acq_len;
  logic             start;
  logic             finish;

  assign acq_len = CNT_W'(acq_periods(acq_sel) * TAD_DIV);
  assign start   = (trig || sw_go) && adc_en && (state_q == SEQ_IDLE);
  assign finish  = (state_q == SEQ_CONV) && conv_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SEQ_IDLE;
      acq_cnt_q    <= '0;
      go_q         <= 1'b0;
      conv_start_q <= 1'b0;
    end else begin
      conv_start_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            go_q <= 1'b1;
            if (acq_len == '0) begin
              state_q      <= SEQ_CONV;
              conv_start_q <= 1'b1;
            end else begin
              state_q   <= SEQ_ACQ;
              acq_cnt_q <= acq_len - 1'b1;
            end
          end
        end
        SEQ_ACQ: begin
          if (acq_cnt_q == '0) begin
            state_q      <= SEQ_CONV;
            conv_start_q <= 1'b1;
          end else begin
            acq_cnt_q <= acq_cnt_q - 1'b1;
          end
        end
        SEQ_CONV: begin
          if (finish) begin
            state_q <= SEQ_IDLE;
            go_q    <= 1'b0;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else if (finish) irq_q <= 1'b1;
    else if (irq_wr && !irq_wr_val) irq_q <= 1'b0;
  end

endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int CONV_LAT = 8,
  localparam int LAT_W = $clog2(CONV_LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done_q
);

  logic             busy_q;
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= LAT_W'(CONV_LAT - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int TAD_DIV  = 2,
  parameter int CONV_LAT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic [TMR_W-1:0] timer_val,
  output logic             trig_evt,
  output logic             go_busy,
  output logic             conv_start,
  output logic             conv_done,
  output logic             adc_irq
);

  logic [TMR_W-1:0] cmp_q;
  logic [3:0]       mode_q;
  logic             adc_en_q;
  logic [2:0]       acq_sel_q;
  logic             sw_go;
  logic             irq_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q     <= '0;
      mode_q    <= '0;
      adc_en_q  <= 1'b0;
      acq_sel_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_CMP) cmp_q <= wr_data;
      if (wr_addr == REG_CTRL) begin
        mode_q    <= wr_data[3:0];
        adc_en_q  <= wr_data[4];
        acq_sel_q <= wr_data[7:5];
      end
    end
  end

  assign sw_go  = wr_en && (wr_addr == REG_GO) && wr_data[0];
  assign irq_wr = wr_en && (wr_addr == REG_IRQ);

  adc_trig_timer #(.TMR_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .trig_mode (mode_q == MODE_ADC_TRIG),
    .cmp_val   (cmp_q),
    .cnt_q     (timer_val),
    .trig_q    (trig_evt)
  );

  adc_trig_seq #(.TAD_DIV(TAD_DIV)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .trig         (trig_evt),
    .sw_go        (sw_go),
    .adc_en       (adc_en_q),
    .acq_sel      (acq_sel_q),
    .irq_wr       (irq_wr),
    .irq_wr_val   (wr_data[0]),
    .conv_done    (conv_done),
    .go_q         (go_busy),
    .conv_start_q (conv_start),
    .irq_q        (adc_irq)
  );

  adc_conv_stub #(.CONV_LAT(CONV_LAT)) u_conv (
    .clk    (clk),
    .rst    (rst),
    .start  (conv_start),
    .done_q (conv_done)
  );

endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk
  import adc_trig_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [TMR_W-1:0] timer_val,
  input logic             trig_evt,
  input logic             go_busy,
  input logic             conv_start,
  input logic             conv_done,
  input logic             adc_irq,
  input logic [3:0]       mode_q,
  input logic             adc_en_q,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             wr_bit0
);

  // R2
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_ADC_TRIG) |=> (timer_val == $past(timer_val) + 1'b1));

  // R3
  trig_clears_timer_chk: assert property (@(posedge clk) disable iff (rst)
    trig_evt |-> (timer_val == '0));

  // R4
  trig_starts_go_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_evt && adc_en_q && !go_busy) |=> go_busy);

  // R5
  disabled_trig_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_evt && !adc_en_q && !go_busy) |=> !go_busy);

  // R6
  go_held_chk: assert property (@(posedge clk) disable iff (rst)
    (go_busy && !conv_done) |=> go_busy);

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_irq && !(wr_en && wr_addr == REG_IRQ && !wr_bit0)) |=> adc_irq);

endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .timer_val  (timer_val),
  .trig_evt   (trig_evt),
  .go_busy    (go_busy),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .adc_irq    (adc_irq),
  .mode_q     (mode_q),
  .adc_en_q   (adc_en_q),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_bit0    (wr_data[0])
);

// File: tb/tb_adc_trig_ctrl.sv
module tb_adc_trig_ctrl;
  localparam int TMR_W    = 16;
  localparam int TAD_DIV  = 2;
  localparam int CONV_LAT = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [TMR_W-1:0] wr_data = '0;
  logic [TMR_W-1:0] timer_val;
  logic             trig_evt, go_busy, conv_start, conv_done, adc_irq;

  int n_chk = 0, n_fail = 0, cyc = 0, conv_seen = 0;
  int go_rise = 0, conv_cyc = 0;
  int exp_q[$];
  logic go_prev = 1'b0, irq_prev = 1'b0;

  adc_trig_ctrl #(.TMR_W(TMR_W), .TAD_DIV(TAD_DIV), .CONV_LAT(CONV_LAT)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .timer_val(timer_val), .trig_evt(trig_evt), .go_busy(go_busy),
    .conv_start(conv_start), .conv_done(conv_done), .adc_irq(adc_irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int acq_len(input int sel);
    case (sel)
      0: return 0;   1: return 2;   2: return 4;   3: return 6;
      4: return 8;   5: return 12;  6: return 16;  default: return 20;
    endcase
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      go_prev  = 1'b0;
      irq_prev = 1'b0;
    end else begin
      if (go_busy && !go_prev) go_rise = cyc;
      if (conv_start) begin
        conv_seen++;
        conv_cyc = cyc;
        if (exp_q.size() == 0)
          check(1'b0, "R7", "unexpected conv_start", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc - go_rise == e, "R7", "go to conv_start cycles", cyc - go_rise, e);
        end
      end
      if (adc_irq && !irq_prev) begin
        check(cyc - conv_cyc == CONV_LAT + 2, "R8", "conv_start to irq cycles",
              cyc - conv_cyc, CONV_LAT + 2);
        check(!go_busy, "R8", "go_busy cleared with irq", int'(go_busy), 0);
      end
      go_prev  = go_busy;
      irq_prev = adc_irq;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [TMR_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_trig(output int c);
    int n = 0;
    do begin @(negedge clk); n++; end while (!trig_evt && n < 2000);
    check(trig_evt, "R3", "trigger seen", int'(trig_evt), 1);
    c = cyc;
  endtask

  task automatic wait_irq();
    int n = 0;
    do begin @(negedge clk); n++; end while (!adc_irq && n < 500);
    check(adc_irq, "R8", "irq seen", int'(adc_irq), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t1, t2, tv0, c0, base;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(timer_val == 0, "R1", "timer in reset", int'(timer_val), 0);
    check(!trig_evt && !go_busy && !conv_start && !adc_irq, "R1", "outputs in reset",
          int'({trig_evt, go_busy, conv_start, adc_irq}), 0);
    rst = 1'b0;

    // R3 / R5: trigger mode, converter disabled
    wr(2'd0, 16'd20);
    wr(2'd1, 16'h000B);
    wait_trig(t1);
    check(timer_val == 0, "R3", "timer zero at trigger", int'(timer_val), 0);
    @(negedge clk);
    check(!trig_evt, "R3", "trigger one cycle", int'(trig_evt), 0);
    check(!go_busy, "R5", "go stays low when disabled", int'(go_busy), 0);
    wait_trig(t2);
    check(t2 - t1 == 21, "R5", "timer still cleared, period", t2 - t1, 21);

    // R4 / R7 / R8: every acquisition selector
    for (int sel = 0; sel < 8; sel++) begin
      do_reset();
      wr(2'd0, 16'd100);
      wr(2'd1, 16'((sel << 5) | 16'h001B));
      exp_q.push_back(TAD_DIV * acq_len(sel));
      wait_trig(t1);
      @(negedge clk);
      check(go_busy, "R4", "go set one cycle after trigger", int'(go_busy), 1);
      wait_irq();
      wr(2'd3, 16'd0);
      check(!adc_irq, "R9", "irq cleared by writing 0", int'(adc_irq), 0);
    end

    // R6: triggers during a busy window
    do_reset();
    wr(2'd0, 16'd10);
    wr(2'd1, 16'h00FB);
    exp_q.push_back(TAD_DIV * 20);
    base = conv_seen;
    wait_trig(t1);
    wait_trig(t2);
    check(t2 - t1 == 11, "R6", "timer cleared while busy", t2 - t1, 11);
    check(go_busy, "R6", "go held while busy", int'(go_busy), 1);
    wr(2'd1, 16'h00EB);
    wait_irq();
    check(conv_seen - base == 1, "R6", "single conversion", conv_seen - base, 1);

    // R9: writing 1 keeps the flag, writing 0 clears it
    wr(2'd3, 16'd1);
    check(adc_irq, "R9", "irq kept on write 1", int'(adc_irq), 1);
    wr(2'd3, 16'd0);
    check(!adc_irq, "R9", "irq cleared on write 0", int'(adc_irq), 0);

    // R10: software go, disabled then enabled
    do_reset();
    wr(2'd2, 16'd1);
    check(!go_busy, "R10", "software go ignored when disabled", int'(go_busy), 0);
    wr(2'd1, 16'h0010);
    exp_q.push_back(0);
    tv0 = int'(timer_val); c0 = cyc;
    wr(2'd2, 16'd1);
    check(go_busy, "R10", "software go sets go", int'(go_busy), 1);
    check(int'(timer_val) - tv0 == cyc - c0, "R10", "timer undisturbed",
          int'(timer_val) - tv0, cyc - c0);
    wait_irq();

    // R2: non-trigger mode free-runs through the compare value
    do_reset();
    wr(2'd0, 16'd5);
    wr(2'd1, 16'h0000);
    tv0 = int'(timer_val);
    t1 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (trig_evt) t1++;
    end
    check(int'(timer_val) - tv0 == 20, "R2", "timer increments", int'(timer_val) - tv0, 20);
    check(t1 == 0, "R2", "no trigger outside mode", t1, 0);
    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule